// File: doc/BRIEF.md
# Selectable-Scheme System Bus Arbiter

This block decides which of several bus masters owns a shared system bus. A two-bit scheme input picks how the decision is made. In the chained scheme, one grant token walks along the masters from position 0 upward, one position per clock, and stops at the first master that is requesting. In the polled scheme, an address counter steps through the masters one per clock, starting from a programmable start address, and stops at the first requesting master. In the independent scheme, a priority decoder picks the lowest-numbered requesting master in one step.

The grant output is registered and one-hot. The winning master raises the shared busy line while it uses the bus. The grant holds for the whole tenure. It clears on the edge that sees busy low again, and arbitration restarts on the following cycle. The scheme is latched when an arbitration starts, so a change on the select input takes effect only once the arbiter is idle. In the polled scheme the start address can be written directly. It can also be rotated automatically to the address after the last winner when a tenure ends, which gives round-robin service.

Top module: `bus_arbiter_sel`

## Requirements
- R1: While reset is high, and on the first cycle after it, grant is all zero.
- R2: Scheme code 2 (independent; code 3 acts the same): when the arbiter is idle, busy is low and any request is high, the grant for the lowest-numbered requesting master appears after that same edge.
- R3: Scheme code 0 (chained): the edge that sees a request while idle launches the token at position 0. The token tests one position per edge, so master k is granted after the (k+2)-th edge counted from the launch edge inclusive.
- R4: Scheme code 1 (polled): polling starts at the start address and moves up one address per edge, wrapping from N-1 to 0. A master at distance d above the start (mod N) is granted after the (d+2)-th edge.
- R5: A polled or chained walk that reaches its last step with no requester returns to idle without a grant. A later request then starts a fresh arbitration.
- R6: A pulse on the start-write input loads the poll start address on that edge. A write takes priority over a rotation on the same edge.
- R7: With rotation enabled, a polled tenure that ends sets the start address to (winner+1) mod N.
- R8: While busy is high no new grant is issued, and a nonzero grant stays unchanged.
- R9: On the edge that sees busy low after a tenure, grant goes to zero. A pending request is arbitrated from the next edge on.
- R10: A change of the scheme input while the arbiter is not idle has no effect on the arbitration in progress. The new scheme applies to the next arbitration started from idle.
- R11: If a granted master drops its request before raising busy, the grant clears on the next edge.
- R12: Grant is always one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scheme_sel | input | 2 | 0 chained, 1 polled, 2 or 3 independent |
| poll_start | input | IDX_W | Start address value for the polled scheme |
| poll_start_wr | input | 1 | Loads poll_start into the start register |
| poll_rotate | input | 1 | Enables start rotation after polled tenures |
| req | input | N_MASTERS | Per-master bus request |
| busy_in | input | 1 | Shared busy line, held by the owner during its tenure |
| grant | output | N_MASTERS | Registered one-hot bus grant |

## Verification
The case that is hardest to reach from the ports is a walk that runs to its end with nobody requesting. It needs a request present on the launch edge that then disappears before the walk tests its position. The stimulus raises a single request for exactly one cycle, then watches the grant stay at zero through the whole sweep. It then checks that a fresh request is polled from the same start address. Scheme changes made in the middle of a walk, and start-address rotation, are checked by counting the edges to the grant, because the winner alone would not tell the orderings apart.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    SCH_CHAIN = 2'd0,
    SCH_POLL  = 2'd1,
    SCH_INDEP = 2'd2
  } scheme_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHAIN,
    ST_POLL,
    ST_HELD,
    ST_TENURE
  } arb_state_e;
endpackage

// File: rtl/arb_lowest_pick.sv
module arb_lowest_pick #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [N_MASTERS-1:0] req,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/arb_chain_walker.sv
module arb_chain_walker #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             advance,
  output logic [IDX_W-1:0] pos,
  output logic             at_end
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_MASTERS - 1);

  always_ff @(posedge clk) begin
    if (rst)          pos <= '0;
    else if (launch)  pos <= '0;
    else if (advance) pos <= pos + 1'b1;
  end

  assign at_end = (pos == LAST);
endmodule

// File: rtl/arb_poll_seq.sv
module arb_poll_seq #(
  parameter int N_MASTERS = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             advance,
  input  logic             load_start,
  input  logic [IDX_W-1:0] load_val,
  input  logic             rot_fire,
  input  logic [IDX_W-1:0] rot_idx,
  output logic [IDX_W-1:0] addr,
  output logic             at_end
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_MASTERS - 1);

  logic [IDX_W-1:0] start_q;
  logic [IDX_W-1:0] steps;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      steps <= '0;
    end else if (launch) begin
      addr  <= start_q;
      steps <= '0;
    end else if (advance) begin
      addr  <= wrap_inc(addr);
      steps <= steps + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             start_q <= '0;
    else if (load_start) start_q <= load_val;
    else if (rot_fire)   start_q <= wrap_inc(rot_idx);
  end

  assign at_end = (steps == LAST);
endmodule

// File: rtl/bus_arbiter_sel.sv
module bus_arbiter_sel
  import bus_arb_pkg::*;
#(
  parameter  int N_MASTERS = 4,
  localparam int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           scheme_sel,
  input  logic [IDX_W-1:0]     poll_start,
  input  logic                 poll_start_wr,
  input  logic                 poll_rotate,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 busy_in,
  output logic [N_MASTERS-1:0] grant
);
  arb_state_e           state;
  scheme_e              cur_scheme;
  scheme_e              sel_s;
  logic [IDX_W-1:0]     win_idx;
  logic [N_MASTERS-1:0] grant_q;

  logic                 any_req;
  logic [IDX_W-1:0]     low_idx;
  logic [IDX_W-1:0]     chain_pos;
  logic [IDX_W-1:0]     poll_addr;
  logic                 chain_end;
  logic                 poll_end;
  logic [IDX_W-1:0]     cursor;
  logic                 hit;
  logic                 walk_end;
  logic                 start_ok;
  logic                 chain_launch;
  logic                 poll_launch;
  logic                 chain_adv;
  logic                 poll_adv;
  logic                 rot_fire;
  logic                 arb_idle;

  function automatic logic [N_MASTERS-1:0] onehot(input logic [IDX_W-1:0] i);
    return N_MASTERS'(1) << i;
  endfunction

  always_comb begin
    unique case (scheme_sel)
      2'd0:    sel_s = SCH_CHAIN;
      2'd1:    sel_s = SCH_POLL;
      default: sel_s = SCH_INDEP;
    endcase
  end

  arb_lowest_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .req (req),
    .any (any_req),
    .idx (low_idx)
  );

  arb_chain_walker #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .launch  (chain_launch),
    .advance (chain_adv),
    .pos     (chain_pos),
    .at_end  (chain_end)
  );

  arb_poll_seq #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_poll (
    .clk        (clk),
    .rst        (rst),
    .launch     (poll_launch),
    .advance    (poll_adv),
    .load_start (poll_start_wr),
    .load_val   (poll_start),
    .rot_fire   (rot_fire),
    .rot_idx    (win_idx),
    .addr       (poll_addr),
    .at_end     (poll_end)
  );

  assign arb_idle     = (state == ST_IDLE);
  assign start_ok     = arb_idle && !busy_in && any_req;
  assign chain_launch = start_ok && (sel_s == SCH_CHAIN);
  assign poll_launch  = start_ok && (sel_s == SCH_POLL);
  assign cursor       = (cur_scheme == SCH_CHAIN) ? chain_pos : poll_addr;
  assign hit          = req[cursor];
  assign walk_end     = (cur_scheme == SCH_CHAIN) ? chain_end : poll_end;
  assign chain_adv    = (state == ST_CHAIN) && !busy_in && !hit && !chain_end;
  assign poll_adv     = (state == ST_POLL) && !busy_in && !hit && !poll_end;
  assign rot_fire     = (state == ST_TENURE) && !busy_in && poll_rotate
                        && (cur_scheme == SCH_POLL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_scheme <= SCH_INDEP;
      win_idx    <= '0;
      grant_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            cur_scheme <= sel_s;
            unique case (sel_s)
              SCH_CHAIN: state <= ST_CHAIN;
              SCH_POLL:  state <= ST_POLL;
              default: begin
                win_idx <= low_idx;
                grant_q <= onehot(low_idx);
                state   <= ST_HELD;
              end
            endcase
          end
        end
        ST_CHAIN, ST_POLL: begin
          if (!busy_in) begin
            if (hit) begin
              win_idx <= cursor;
              grant_q <= onehot(cursor);
              state   <= ST_HELD;
            end else if (walk_end) begin
              state <= ST_IDLE;
            end
          end
        end
        ST_HELD: begin
          if (busy_in) begin
            state <= ST_TENURE;
          end else if (!req[win_idx]) begin
            grant_q <= '0;
            state   <= ST_IDLE;
          end
        end
        ST_TENURE: begin
          if (!busy_in) begin
            grant_q <= '0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/bus_arb_sel_chk.sv
module bus_arb_sel_chk #(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           scheme_sel,
  input logic [N_MASTERS-1:0] req,
  input logic                 busy_in,
  input logic [N_MASTERS-1:0] grant,
  input logic                 arb_idle,
  input logic [1:0]           cur_scheme
);
  assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_hold_in_tenure_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_in && grant != '0) |=> (grant == $past(grant)));

  assert_no_new_grant_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_in && grant == '0) |=> (grant == '0));

  assert_release_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !busy_in && $past(busy_in)) |=> (grant == '0));

  assert_withdraw_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !busy_in && (grant & req) == '0) |=> (grant == '0));

  assert_indep_lowest_R2: assert property (@(posedge clk) disable iff (rst)
    (arb_idle && !busy_in && req != '0 && scheme_sel == 2'd2)
    |=> (grant == ($past(req) & (~$past(req) + 1'b1))));

  assert_scheme_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !arb_idle |=> $stable(cur_scheme));
endmodule

bind bus_arbiter_sel bus_arb_sel_chk #(.N_MASTERS(N_MASTERS)) u_arb_chk (
  .clk        (clk),
  .rst        (rst),
  .scheme_sel (scheme_sel),
  .req        (req),
  .busy_in    (busy_in),
  .grant      (grant),
  .arb_idle   (arb_idle),
  .cur_scheme (cur_scheme)
);

// File: tb/test_bus_arbiter_sel.sv
`timescale 1ns/1ps
module test_bus_arbiter_sel;
  localparam int NM = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    scheme_sel = 2'd2;
  logic [1:0]    poll_start = '0;
  logic          poll_start_wr = 1'b0;
  logic          poll_rotate = 1'b0;
  logic [NM-1:0] req = '0;
  logic          busy_in = 1'b0;
  logic [NM-1:0] grant;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  bus_arbiter_sel #(.N_MASTERS(NM)) i_bus_arbiter_sel (
    .clk           (clk),
    .rst           (rst),
    .scheme_sel    (scheme_sel),
    .poll_start    (poll_start),
    .poll_start_wr (poll_start_wr),
    .poll_rotate   (poll_rotate),
    .req           (req),
    .busy_in       (busy_in),
    .grant         (grant)
  );

  // Behavioural reference: 0 idle, 1 chain walk, 2 poll walk, 3 granted, 4 tenure
  int            m_state = 0;
  int            m_sch   = 2;
  int            m_cur   = 0;
  int            m_steps = 0;
  int            m_start = 0;
  int            m_win   = -1;
  logic [NM-1:0] exp_grant = '0;

  function automatic int lowest(input logic [NM-1:0] r);
    for (int i = 0; i < NM; i++) if (r[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    int nstart;
    if (rst) begin
      m_state = 0; m_sch = 2; m_cur = 0; m_steps = 0; m_start = 0; m_win = -1;
    end else begin
      nstart = m_start;
      case (m_state)
        0: if (!busy_in && req != 0) begin
             m_sch = (scheme_sel == 2'd3) ? 2 : int'(scheme_sel);
             if (m_sch == 2) begin m_win = lowest(req); m_state = 3; end
             else if (m_sch == 0) begin m_cur = 0; m_state = 1; end
             else begin m_cur = m_start; m_steps = 0; m_state = 2; end
           end
        1, 2: if (!busy_in) begin
             if (req[m_cur]) begin m_win = m_cur; m_state = 3; end
             else if ((m_state == 1 && m_cur == NM-1) ||
                      (m_state == 2 && m_steps == NM-1)) m_state = 0;
             else begin m_cur = (m_cur + 1) % NM; m_steps++; end
           end
        3: if (busy_in) m_state = 4;
           else if (!req[m_win]) begin m_win = -1; m_state = 0; end
        default: if (!busy_in) begin
             if (poll_rotate && m_sch == 1) nstart = (m_win + 1) % NM;
             m_win = -1; m_state = 0;
           end
      endcase
      if (poll_start_wr) nstart = int'(poll_start);
      m_start = nstart;
    end
    exp_grant = (m_win < 0) ? '0 : NM'(1) << m_win;
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      vectors++;
      if (grant !== exp_grant) begin
        misses++;
        $display("FAIL R2 R3 R4 R9 per-cycle model: grant=%b expected %b", grant, exp_grant);
      end
      if ($countones(grant) > 1) begin
        misses++;
        $display("FAIL R12 onehot: grant=%b expected at most one bit", grant);
      end
    end
    if (cycles > 150000 && !done) begin
      misses++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      done = 1;
      report();
    end
  end

  // Bus master agent, stepped from the stimulus process only
  bit auto_en = 1;
  int hold_len = 3;
  int rem = 0;
  bit in_ten = 0;
  int who = 0;

  task automatic agent_step;
    if (!auto_en) return;
    if (in_ten) begin
      if (rem > 1) rem--;
      else begin busy_in = 1'b0; req[who] = 1'b0; in_ten = 0; end
    end else if (grant != 0 && !busy_in) begin
      who = lowest(grant); busy_in = 1'b1; rem = hold_len; in_ten = 1;
    end
  endtask

  task automatic tick;
    @(negedge clk);
    agent_step();
  endtask

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_grant(output int cnt);
    cnt = 0;
    do begin tick(); cnt++; end while (grant == 0 && cnt < 60);
  endtask

  task automatic drain;
    int n = 0;
    while ((req != 0 || in_ten || busy_in || grant != 0) && n < 400) begin tick(); n++; end
    tick();
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check("R1 grant in reset", int'(grant), 0);
    rst = 1'b0;
    tick();
    check("R1 grant after reset", int'(grant), 0);

    // Independent scheme
    scheme_sel = 2'd2; req = 4'b1010;
    wait_grant(c);
    check("R2 latency", c, 1);
    check("R2 winner", int'(grant), 4'b0010);
    for (int i = 0; i < 3; i++) begin tick(); check("R8 grant held", int'(grant), 4'b0010); end
    tick(); check("R9 grant cleared", int'(grant), 0);
    tick(); check("R9 restart winner", int'(grant), 4'b1000);
    drain();

    // Chained scheme
    scheme_sel = 2'd0; req = 4'b0100;
    wait_grant(c); check("R3 latency pos2", c, 4); check("R3 winner", int'(grant), 4'b0100);
    drain();
    req = 4'b1001;
    wait_grant(c); check("R3 latency pos0", c, 2); check("R3 winner low", int'(grant), 4'b0001);
    drain();
    req = 4'b1000;
    wait_grant(c); check("R3 latency pos3", c, 5);
    drain();

    // Polled scheme with a loaded start
    scheme_sel = 2'd1; poll_start = 2'd2; poll_start_wr = 1'b1; tick(); poll_start_wr = 1'b0;
    req = 4'b0010;
    wait_grant(c); check("R6 R4 wrap latency", c, 5); check("R4 winner", int'(grant), 4'b0010);
    drain();
    req = 4'b1011;
    wait_grant(c); check("R4 latency from start", c, 3); check("R4 winner", int'(grant), 4'b1000);
    drain();

    // Rotation
    poll_start = 2'd2; poll_start_wr = 1'b1; tick(); poll_start_wr = 1'b0;
    poll_rotate = 1'b1; req = 4'b0101;
    wait_grant(c); check("R7 first winner", int'(grant), 4'b0100);
    c = 0; while (grant != 0 && c < 60) begin tick(); c++; end
    wait_grant(c); check("R7 rotated latency", c, 3); check("R7 rotated winner", int'(grant), 4'b0001);
    drain();
    req = 4'b0110;
    wait_grant(c); check("R7 start after winner", c, 2); check("R7 winner", int'(grant), 4'b0010);
    drain();
    poll_rotate = 1'b0;

    // Empty sweep
    poll_start = 2'd1; poll_start_wr = 1'b1; tick(); poll_start_wr = 1'b0;
    req = 4'b0001; tick(); req = 4'b0000;
    for (int i = 0; i < 6; i++) begin tick(); check("R5 no grant on empty sweep", int'(grant), 0); end
    req = 4'b0100;
    wait_grant(c); check("R5 fresh poll latency", c, 3); check("R5 fresh winner", int'(grant), 4'b0100);
    drain();

    // Scheme change mid-walk
    scheme_sel = 2'd0; req = 4'b1000; tick(); scheme_sel = 2'd2;
    wait_grant(c); check("R10 old scheme kept", c + 1, 5);
    drain();
    req = 4'b0100;
    wait_grant(c); check("R10 new scheme after idle", c, 1);
    drain();

    // Withdrawal before busy
    auto_en = 0; scheme_sel = 2'd2; req = 4'b0001;
    wait_grant(c); check("R11 granted", int'(grant), 4'b0001);
    req = 4'b0000; tick();
    check("R11 grant withdrawn", int'(grant), 0);
    auto_en = 1; tick();

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      tick();
      if ($urandom_range(0, 3) == 0) req = req | NM'($urandom_range(0, 15));
      if ($urandom_range(0, 20) == 0) scheme_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 30) == 0) poll_rotate = ~poll_rotate;
      poll_start_wr = ($urandom_range(0, 25) == 0);
      poll_start = 2'($urandom_range(0, 3));
      if (!in_ten) hold_len = $urandom_range(1, 4);
    end
    poll_start_wr = 1'b0;
    drain();
    done = 1;
    report();
  end
endmodule